// File: doc/BRIEF.md
# Modulus-Reload Periodic Interval Timer

A 16-bit periodic interval timer whose counter runs in a slow reference domain, separate from the processor bus. A free-running reference clock (nominally 32.768 kHz) is divided by four to produce a count tick. On each tick the counter steps down by one. A modulus latch holds the value the counter starts from. Each time the count passes through zero, a zero event is raised and crossed into the bus domain, where it sets a sticky interrupt flag.

Software uses a small register port in the faster bus clock domain. It writes and reads back the modulus, reads a coherent copy of the live count at a separate address, and sets the control bits. Run enables counting. Reload selects the periodic mode, in which the counter takes values only from the modulus latch. Interrupt-enable gates the interrupt pin. Writes to the modulus are carried to the count domain by a toggle handshake. The live count is carried back by a second toggle handshake, so the bus never samples a changing value. The register port has no back-pressure: every write is taken in the cycle it is presented.

Top module: `modrel_interval_timer`

Register map (bus_addr): 0 = control/status, 1 = modulus, 2 = live count, 3 = reads zero. Control/status bits: bit 0 run, bit 1 reload, bit 2 interrupt-enable, bit 3 zero flag (read; write one to clear).

## Requirements
- R1: After reset, every address reads 0, the counter is 0 and irq is low.
- R2: Address 1 reads back the last value written there, whether or not the counter is running, never the live count.
- R3: With run and reload set and modulus M, the count goes M, M-1, ..., 0 and then reloads M, giving one zero event every (M+1)*4 reference cycles; the value read at address 2 stays within 0..M.
- R4: With reload set, a modulus write leaves the running count untouched; the new value first appears when the count next reloads from zero.
- R5: With reload clear, the counter wraps from 0 to 0xFFFF, and this wrap counts as a zero event.
- R6: With reload clear, a modulus write is loaded into the counter on the first count tick after it reaches the count domain.
- R7: With run clear, the count is frozen; the first count tick after run is set loads the counter from the modulus latch.
- R8: Each zero event sets bit 3 of address 0. Writing 1 to bit 3 clears it, writing 0 leaves it, and a new event in the same cycle wins over a clear.
- R9: irq is high exactly when the zero flag and interrupt-enable (bit 2) are both set.
- R10: The value read at address 2 is a count the counter actually held, copied only while the copy register is stable; successive reads never rise while counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Bus clock; must be at least as fast as ref_clk |
| ref_clk | input | 1 | Low-rate reference clock, divided by four into count ticks |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized in each domain |
| bus_wr | input | 1 | Single-cycle write strobe, bus clock domain |
| bus_addr | input | 2 | Register address: 0 control/status, 1 modulus, 2 live count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request: zero flag AND interrupt-enable |

## Verification
The assertions assume the bus clock is never slower than the reference clock. They also assume bus_wr is a one-cycle strobe in the bus domain, so every handshake toggle is seen by the far side before it can toggle again. The bench runs the bus clock at 50 MHz and the reference at 10 MHz with an offset phase, so edges of the two clocks never coincide. It gives each crossing tens of bus cycles to settle before judging a result. Interval checks compare the spacing of two successive interrupt rises, so the fixed crossing latency cancels out.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    ADDR_CSR = 2'd0,
    ADDR_MOD = 2'd1,
    ADDR_CNT = 2'd2,
    ADDR_RSV = 2'd3
  } pit_addr_e;

  localparam int B_RUN    = 0;
  localparam int B_RELOAD = 1;
  localparam int B_IRQEN  = 2;
  localparam int B_FLAG   = 3;
  localparam int CSR_BITS = 4;
endpackage

// File: rtl/pit_sync.sv
module pit_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R3: ticks are spaced, never back to back
      p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          reload,
  input  logic          mod_load,
  input  logic [CW-1:0] mod_val,
  output logic [CW-1:0] cnt,
  output logic          evt_tgl
);
  logic [CW-1:0] mod_q;
  logic          mod_new;
  logic          started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      mod_q   <= '0;
      mod_new <= 1'b0;
      started <= 1'b0;
      evt_tgl <= 1'b0;
    end else begin
      if (!run) begin
        started <= 1'b0;
      end else if (tick) begin
        if (!started) begin
          cnt     <= mod_q;
          started <= 1'b1;
          mod_new <= 1'b0;
        end else if (mod_new && !reload) begin
          cnt     <= mod_q;
          mod_new <= 1'b0;
        end else if (cnt == '0) begin
          cnt     <= reload ? mod_q : '1;
          evt_tgl <= ~evt_tgl;
          if (reload) mod_new <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      // a capture in the same cycle as a load stays pending for the next tick
      if (mod_load) begin
        mod_q   <= mod_val;
        mod_new <= 1'b1;
      end
    end
  end

  // R3: a plain tick steps the count down by exactly one
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && started && cnt != '0 && !(mod_new && !reload))
      |=> (cnt == $past(cnt) - 1'b1));

  // R3: in reload mode, zero is followed by the latched modulus
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && started && cnt == '0 && reload)
      |=> (cnt == $past(mod_q)));

  // R5: in free-run mode, zero wraps to all ones
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && started && cnt == '0 && !reload && !mod_new)
      |=> (cnt == '1));

  // R7: the count is frozen while run is clear
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));
endmodule

// File: rtl/pit_snap_tx.sv
module pit_snap_tx #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          ack_s,
  output logic [CW-1:0] snap,
  output logic          tgl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= '0;
      tgl  <= 1'b0;
    end else if (tgl == ack_s) begin
      snap <= cnt;
      tgl  <= ~tgl;
    end
  end

  // R10: the copy holds still while the bus side has not acknowledged it
  p_snap_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl != ack_s) |=> $stable(snap));
endmodule

// File: rtl/modrel_interval_timer.sv
module modrel_interval_timer
  import pit_pkg::*;
#(
  parameter int CW          = 16,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          cpu_clk,
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq
);
  // ---------------- reset release per domain ----------------
  logic cpu_rst_n, ref_rst_n;

  pit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_cpu_rst (
    .clk(cpu_clk), .rst_n(rst_n), .d(1'b1), .q(cpu_rst_n));
  pit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n));

  // ---------------- bus-domain state ----------------
  logic          run_q, reload_q, irqen_q, flag_q;
  logic [CW-1:0] mod_latch, mod_shadow, cnt_view;
  logic          mod_req, mod_dirty;
  logic          evt_seen, snap_seen;

  // ---------------- ref-domain state ----------------
  logic [1:0]    ctl_s;
  logic          req_s, req_d, mod_load;
  logic          tick;
  logic [CW-1:0] cnt, snap;
  logic          evt_tgl, snap_tgl, snap_ack_s;

  // crossings into the bus domain
  logic mod_ack_s, evt_s, snap_s;

  pit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .d(req_d), .q(mod_ack_s));
  pit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_evt_sync (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .d(evt_tgl), .q(evt_s));
  pit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_snap_sync (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .d(snap_tgl), .q(snap_s));

  logic wr_csr, wr_mod, mod_idle, evt_hit, unused_wdata;
  assign wr_csr       = bus_wr && (bus_addr == ADDR_CSR);
  assign wr_mod       = bus_wr && (bus_addr == ADDR_MOD);
  assign mod_idle     = (mod_req == mod_ack_s);
  assign evt_hit      = (evt_s != evt_seen);
  assign unused_wdata = ^bus_wdata[CW-1:CSR_BITS];

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      run_q      <= 1'b0;
      reload_q   <= 1'b0;
      irqen_q    <= 1'b0;
      flag_q     <= 1'b0;
      mod_latch  <= '0;
      mod_shadow <= '0;
      mod_req    <= 1'b0;
      mod_dirty  <= 1'b0;
      evt_seen   <= 1'b0;
      snap_seen  <= 1'b0;
      cnt_view   <= '0;
    end else begin
      if (wr_csr) begin
        run_q    <= bus_wdata[B_RUN];
        reload_q <= bus_wdata[B_RELOAD];
        irqen_q  <= bus_wdata[B_IRQEN];
      end
      evt_seen <= evt_s;
      if (evt_hit)                          flag_q <= 1'b1;
      else if (wr_csr && bus_wdata[B_FLAG]) flag_q <= 1'b0;

      if (wr_mod) mod_latch <= bus_wdata;
      if (mod_idle && (mod_dirty || wr_mod)) begin
        mod_shadow <= wr_mod ? bus_wdata : mod_latch;
        mod_req    <= ~mod_req;
        mod_dirty  <= 1'b0;
      end else if (wr_mod) begin
        mod_dirty <= 1'b1;
      end

      if (snap_s != snap_seen) begin
        cnt_view  <= snap;
        snap_seen <= snap_s;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CSR: bus_rdata = CW'({flag_q, irqen_q, reload_q, run_q});
      ADDR_MOD: bus_rdata = mod_latch;
      ADDR_CNT: bus_rdata = cnt_view;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = flag_q & irqen_q;

  // ---------------- count domain ----------------
  pit_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d({reload_q, run_q}), .q(ctl_s));
  pit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(mod_req), .q(req_s));
  pit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sack_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(snap_seen), .q(snap_ack_s));

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) req_d <= 1'b0;
    else            req_d <= req_s;
  end
  assign mod_load = (req_s != req_d);

  pit_prescaler #(.DIV(DIV)) u_presc (
    .clk(ref_clk), .rst_n(ref_rst_n), .tick(tick));

  pit_count_core #(.CW(CW)) u_core (
    .clk(ref_clk), .rst_n(ref_rst_n), .tick(tick),
    .run(ctl_s[0]), .reload(ctl_s[1]),
    .mod_load(mod_load), .mod_val(mod_shadow),
    .cnt(cnt), .evt_tgl(evt_tgl));

  pit_snap_tx #(.CW(CW)) u_snap (
    .clk(ref_clk), .rst_n(ref_rst_n), .cnt(cnt),
    .ack_s(snap_ack_s), .snap(snap), .tgl(snap_tgl));

  // ---------------- bus-domain checks ----------------
  // R8: the flag stays set unless a write-one clears it
  p_flag_sticky_r8: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (flag_q && !(wr_csr && bus_wdata[B_FLAG])) |=> flag_q);

  // R2: the modulus latch changes only through a modulus write
  p_latch_hold_r2: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    !wr_mod |=> $stable(mod_latch));

  // R4: the value in flight to the count domain holds until acknowledged
  p_shadow_hold_r4: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (mod_req != mod_ack_s) |=> $stable(mod_shadow));
endmodule

// File: tb/modrel_interval_timer_test.sv
module modrel_interval_timer_test;
  logic        cpu_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        bus_wr  = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [1:0] A_CSR = 2'd0, A_MOD = 2'd1, A_CNT = 2'd2, A_RSV = 2'd3;
  // control/status: bit0 run, bit1 reload, bit2 irq enable, bit3 flag (w1c)
  localparam int NV = 6;
  localparam logic [15:0] VEC_MOD [NV] = '{16'd0, 16'd1, 16'd2, 16'd5, 16'd9, 16'd31};
  // (M+1) ticks * 4 reference cycles * 100 ns
  localparam int VEC_PER_NS [NV] = '{400, 800, 1200, 2400, 4000, 12800};

  always #10 cpu_clk = ~cpu_clk;
  initial begin
    #3;
    forever #50 ref_clk = ~ref_clk;
  end

  modrel_interval_timer uut (
    .cpu_clk(cpu_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge cpu_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge cpu_clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge cpu_clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic wait_irq(output longint t, output bit seen);
    seen = 1'b0; t = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge cpu_clk);
      if (irq) begin seen = 1'b1; t = longint'($time); end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge cpu_clk);
  endtask

  initial begin
    repeat (150000) @(posedge cpu_clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd, rd2;
    longint t1, t2;
    bit s1, s2;

    idle(5);
    rst_n = 1'b1;
    idle(10);

    // R1: reset state
    bus_read(A_CSR, rd); check("R1 csr", rd == 0, rd, 0);
    bus_read(A_MOD, rd); check("R1 modulus", rd == 0, rd, 0);
    bus_read(A_CNT, rd); check("R1 count", rd == 0, rd, 0);
    bus_read(A_RSV, rd); check("R1 spare", rd == 0, rd, 0);
    check("R1 irq", irq == 1'b0, irq, 0);

    // R3 period table, with R2 readback
    for (int v = 0; v < NV; v++) begin
      bus_write(A_CSR, 16'h0008);
      bus_write(A_MOD, VEC_MOD[v]);
      idle(30);
      bus_write(A_CSR, 16'h000F);
      wait_irq(t1, s1);
      bus_write(A_CSR, 16'h000F);
      wait_irq(t2, s2);
      check("R3 period", s1 && s2 && (t2 - t1 >= VEC_PER_NS[v] - 20) &&
            (t2 - t1 <= VEC_PER_NS[v] + 20), t2 - t1, VEC_PER_NS[v]);
      bus_read(A_MOD, rd);
      check("R2 modulus readback", rd == VEC_MOD[v], rd, VEC_MOD[v]);
      bus_read(A_CNT, rd);
      check("R3 count in range", rd <= VEC_MOD[v], rd, VEC_MOD[v]);
    end

    // R8 / R9: flag without interrupt enable, then write-one-to-clear
    bus_write(A_CSR, 16'h0008);
    bus_write(A_MOD, 16'd1);
    idle(30);
    bus_write(A_CSR, 16'h000B);
    idle(300);
    check("R9 irq gated off", irq == 1'b0, irq, 0);
    bus_read(A_CSR, rd);
    check("R8 flag set", rd[3] == 1'b1, rd[3], 1);
    bus_write(A_CSR, 16'h0002);
    idle(50);
    bus_read(A_CSR, rd);
    check("R8 write zero keeps flag", rd == 16'h000A, rd, 16'h000A);
    bus_write(A_CSR, 16'h0006);
    idle(2);
    check("R9 irq follows enable", irq == 1'b1, irq, 1);
    bus_write(A_CSR, 16'h000E);
    idle(2);
    bus_read(A_CSR, rd);
    check("R8 write one clears", rd == 16'h0006, rd, 16'h0006);
    check("R9 irq drops", irq == 1'b0, irq, 0);

    // R7: frozen while stopped, load on first tick after run
    bus_write(A_CSR, 16'h0002);
    idle(100);
    bus_read(A_CNT, rd);
    idle(200);
    bus_read(A_CNT, rd2);
    check("R7 frozen", rd == rd2, rd2, rd);
    bus_write(A_MOD, 16'd50);
    idle(30);
    bus_write(A_CSR, 16'h0003);
    idle(120);
    bus_read(A_CNT, rd);
    check("R7 load on start", rd >= 16'd44 && rd <= 16'd50, rd, 50);

    // R4 / R10: reload mode ignores a mid-count modulus write
    bus_write(A_CSR, 16'h0008);
    bus_write(A_MOD, 16'd200);
    idle(30);
    bus_write(A_CSR, 16'h000F);
    idle(200);
    bus_read(A_CNT, rd);
    idle(20);
    bus_read(A_CNT, rd2);
    check("R10 coherent step", rd2 <= rd && (rd - rd2) <= 2 && rd <= 200, rd2, rd);
    bus_write(A_MOD, 16'd2);
    idle(200);
    bus_read(A_CNT, rd);
    check("R4 count untouched", rd > 16'd2 && rd <= 16'd200, rd, 190);
    bus_read(A_MOD, rd);
    check("R2 readback while running", rd == 16'd2, rd, 2);
    wait_irq(t1, s1);
    bus_write(A_CSR, 16'h000F);
    wait_irq(t2, s2);
    check("R4 new modulus after reload", s1 && s2 && (t2 - t1 >= 1180) &&
          (t2 - t1 <= 1220), t2 - t1, 1200);

    // R5 / R6: free-running mode
    bus_write(A_CSR, 16'h0008);
    bus_write(A_MOD, 16'd3);
    idle(30);
    bus_write(A_CSR, 16'h000D);
    wait_irq(t1, s1);
    check("R5 wrap raises event", s1, s1, 1);
    idle(80);
    bus_read(A_CNT, rd);
    check("R5 wrap to all ones", rd >= 16'hFFF0, rd, 16'hFFFF);
    bus_write(A_MOD, 16'd7);
    idle(120);
    bus_read(A_CNT, rd);
    check("R6 modulus loaded in free-run", rd <= 16'd7, rd, 7);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule